// File: doc/BRIEF.md
# Host Status/Control Register with Sticky Interrupt Capture

This block is the 16-bit status and control word that a host uses to supervise a serial-bus protocol engine. A host read returns a status word. That word combines sticky copies of the engine's two short interrupt pulses, three software-held mode bits, and two live engine signals. A host write is a command word. Each function has its own set bit and its own clear bit, so one write can change several functions without a read-modify-write. A bit written as zero leaves its function alone.

The two interrupt inputs arrive from another clock domain as pulses of roughly 125 ns. Each input passes through a synchronizer with edge detection. The resulting one-cycle event sets a sticky latch. The latches set whether or not interrupts are enabled, so the host can poll them. The host interrupt request is raised when interrupts are enabled and at least one latch is set. The block also makes the timer clock enable for the engine: a base tick every `TICK_DIV` cycles, or that tick divided by `SLOW_DIV` when the resolution bit is set. A command bit sends a one-cycle master reset to the engine and also returns this block's latches and mode bits to zero.

Top module: `host_ctl_status`

## Requirements
- R1: Status word layout. Bit 0 is the message latch and bit 1 is the fail latch. Bit 2 is interrupt enable and bit 4 is the subsystem flag. Bit 6 mirrors `eng_active`, bit 7 mirrors `eng_ready`, and bit 8 is timer resolution. Bits 3, 5 and 9 to 15 read as zero.
- R2: A rising edge on `msg_pulse` or `fail_pulse` that stays high for at least two clock cycles sets its latch within three clock edges. This happens whether interrupt enable is set or not.
- R3: A set latch stays set until a write has a one in command bit 0 (message) or command bit 1 (fail). The latch then reads zero after that clock edge. Clearing one latch does not affect the other latch.
- R4: If a latch's capture event falls in the same cycle as a write that clears that latch, the latch stays set.
- R5: Command bit pairs set and clear interrupt enable (bits 2 and 3), the subsystem flag (bits 4 and 5) and timer resolution (bits 8 and 9). When both bits of a pair are one in the same write, the function is cleared.
- R6: A command bit written as zero has no effect. Bits 6 and 10 to 15 have no command function.
- R7: `irq` is high when interrupt enable is set and at least one latch is set. Otherwise it is low.
- R8: A write with command bit 7 set drives `eng_reset` high for exactly the next cycle. The same write clears both latches, interrupt enable, the subsystem flag and timer resolution.
- R9: With timer resolution at zero, `tmr_tick` pulses once every `TICK_DIV` cycles. With timer resolution at one, it pulses once every `TICK_DIV*SLOW_DIV` cycles.
- R10: After reset, the status word is zero apart from the live bits 6 and 7, and `irq` and `eng_reset` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 16 | Command word |
| msg_pulse | input | 1 | Asynchronous message-interrupt pulse from the engine |
| fail_pulse | input | 1 | Asynchronous fail-interrupt pulse from the engine |
| eng_active | input | 1 | Engine is processing a command |
| eng_ready | input | 1 | Engine has finished initialization |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Host interrupt request |
| eng_reset | output | 1 | One-cycle master reset to the engine |
| tmr_tick | output | 1 | Timer clock enable to the engine |

## Verification
The bench lines a capture event up with a clear write in the same cycle. A design that let the clear win would lose that interrupt without a trace. It also writes both bits of each set/clear pair together; a design where the set bit won would leave the function on. Zero and unused-bit writes are checked for side effects, and clearing one latch is checked for disturbing the other. The bench counts timer ticks in both resolutions, so a divider off by one, or a select that has no effect, shows up as a wrong count.

// File: rtl/host_ctl_status.sv
module host_ctl_status #(
  parameter int TICK_DIV = 1000,
  parameter int SLOW_DIV = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        msg_pulse,
  input  logic        fail_pulse,
  input  logic        eng_active,
  input  logic        eng_ready,
  output logic [15:0] rd_data,
  output logic        irq,
  output logic        eng_reset,
  output logic        tmr_tick
);
  localparam int FW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [15:0] cmd;
  logic [1:0]  raw, evt, lat;
  logic        ie, sub, tres;
  logic [FW-1:0] fcnt;
  logic [SW-1:0] scnt;
  logic        fast_tick, slow_tick;

  assign cmd = wr_en ? wr_data : 16'h0;
  assign raw = {fail_pulse, msg_pulse};

  for (genvar i = 0; i < 2; i++) begin : g_cap
    logic [2:0] sy;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sy <= '0;
      else        sy <= {sy[1:0], raw[i]};
    assign evt[i] = sy[1] & ~sy[2];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lat[i] <= 1'b0;
      else        lat[i] <= evt[i] | (lat[i] & ~cmd[i] & ~cmd[7]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie <= 1'b0; sub <= 1'b0; tres <= 1'b0; eng_reset <= 1'b0;
    end else begin
      eng_reset <= cmd[7];
      if (cmd[7] || cmd[3]) ie <= 1'b0;
      else if (cmd[2])      ie <= 1'b1;
      if (cmd[7] || cmd[5]) sub <= 1'b0;
      else if (cmd[4])      sub <= 1'b1;
      if (cmd[7] || cmd[9]) tres <= 1'b0;
      else if (cmd[8])      tres <= 1'b1;
    end

  assign fast_tick = (fcnt == FW'(TICK_DIV - 1));
  assign slow_tick = fast_tick && (scnt == SW'(SLOW_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fcnt <= '0; scnt <= '0;
    end else begin
      fcnt <= fast_tick ? '0 : fcnt + 1'b1;
      if (fast_tick) scnt <= (scnt == SW'(SLOW_DIV - 1)) ? '0 : scnt + 1'b1;
    end

  assign tmr_tick = tres ? slow_tick : fast_tick;
  assign irq      = ie & (|lat);
  assign rd_data  = {7'b0, tres, eng_ready, eng_active, 1'b0, sub, 1'b0, ie, lat};

  logic unused_cmd;
  assign unused_cmd = &{1'b0, cmd[15:10], cmd[6]};
endmodule

// File: rtl/host_ctl_status_chk.sv
module host_ctl_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic        eng_reset
);
  assert_sticky_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !(wr_en && (wr_data[0] || wr_data[7]))) |=> rd_data[0]);

  assert_sticky_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !(wr_en && (wr_data[1] || wr_data[7]))) |=> rd_data[1]);

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && wr_data[3]) |=> !rd_data[2]);

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({rd_data[8], rd_data[4], rd_data[2]}));

  assert_no_irq_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> !irq);

  assert_mreset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7]) |=> (eng_reset && !rd_data[2] && !rd_data[4] && !rd_data[8]));

  assert_mreset_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reset |-> $past(wr_en && wr_data[7]));
endmodule

bind host_ctl_status host_ctl_status_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .eng_reset(eng_reset)
);

// File: tb/host_ctl_status_test.sv
module host_ctl_status_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic msg_pulse = 1'b0, fail_pulse = 1'b0, eng_active = 1'b0, eng_ready = 1'b0;
  logic [15:0] rd_data;
  logic irq, eng_reset, tmr_tick;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_ctl_status #(.TICK_DIV(4), .SLOW_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .msg_pulse(msg_pulse), .fail_pulse(fail_pulse),
    .eng_active(eng_active), .eng_ready(eng_ready),
    .rd_data(rd_data), .irq(irq), .eng_reset(eng_reset), .tmr_tick(tmr_tick));

  // {command word, expected status} ; R5 / R6 walk
  localparam logic [31:0] VEC [12] = '{
    {16'h0004, 16'h0004},  // R5 set enable
    {16'h0010, 16'h0014},  // R5 set flag
    {16'h0100, 16'h0114},  // R5 set resolution
    {16'h0008, 16'h0110},  // R5 clear enable
    {16'h0000, 16'h0110},  // R6 zero write
    {16'h0030, 16'h0100},  // R5 both -> clear flag
    {16'h0300, 16'h0000},  // R5 both -> clear resolution
    {16'h0004, 16'h0004},  // R5
    {16'h000C, 16'h0000},  // R5 both -> clear enable
    {16'hFC40, 16'h0000},  // R6 unused bits
    {16'h0114, 16'h0114},  // R5 set three at once
    {16'h0228, 16'h0000}   // R5 clear three at once
  };

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(bit fail);
    @(negedge clk);
    if (fail) fail_pulse = 1'b1; else msg_pulse = 1'b1;
    repeat (31) @(negedge clk);
    fail_pulse = 1'b0; msg_pulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_ticks(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tmr_tick) c++;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R10 status", rd_data, 16'h0000);
    check("R10 irq", {15'b0, irq}, 16'h0);
    check("R10 eng_reset", {15'b0, eng_reset}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", rd_data, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][31:16]);
      check("R5/R6 vector", rd_data, VEC[i][15:0]);
    end

    // R1 live bits
    eng_active = 1'b1; #1;
    check("R1 active", rd_data, 16'h0040);
    eng_ready = 1'b1; eng_active = 1'b0; #1;
    check("R1 ready", rd_data, 16'h0080);
    eng_ready = 1'b0;

    // R2 capture while disabled, R7 no irq
    pulse(1'b1);
    check("R2 fail latched, enable off", rd_data, 16'h0002);
    check("R7 irq off when disabled", {15'b0, irq}, 16'h0);
    wr(16'h0004);
    check("R7 irq on", {15'b0, irq}, 16'h1);
    pulse(1'b0);
    check("R2 msg latched", rd_data, 16'h0007);
    wr(16'h0001);
    check("R3 msg cleared, fail kept", rd_data, 16'h0006);
    check("R7 irq still on", {15'b0, irq}, 16'h1);
    wr(16'h0002);
    check("R3 fail cleared", rd_data, 16'h0004);
    check("R7 irq off no latch", {15'b0, irq}, 16'h0);

    // R4 event coincident with clear
    @(negedge clk); msg_pulse = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0001;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R4 event beats clear", rd_data, 16'h0005);
    repeat (30) @(negedge clk); msg_pulse = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 latch holds", rd_data, 16'h0005);

    // R8 master reset
    pulse(1'b1);
    wr(16'h0110);
    check("R8 before", rd_data, 16'h0117);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0080;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R8 eng_reset high", {15'b0, eng_reset}, 16'h1);
    check("R8 state cleared", rd_data, 16'h0000);
    @(negedge clk);
    check("R8 eng_reset one cycle", {15'b0, eng_reset}, 16'h0);

    // R9 timer
    count_ticks(64, c);
    check("R9 fast ticks", 16'(c), 16'd16);
    wr(16'h0100);
    count_ticks(64, c);
    check("R9 slow ticks", 16'(c), 16'd4);
    wr(16'h0200);
    count_ticks(64, c);
    check("R9 fast again", 16'(c), 16'd16);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule